// File: doc/BRIEF.md
# Playback Sample FIFO with Burst Service Request

This block sits between a write port, fed by a bus master or a DMA engine that writes every sample to one fixed data-register address, and a serial audio transmitter that pulls one sample at a time. Samples are held in a first-in first-out store of 32 entries by default. When the fill level drops to a programmable mark, and there is room for a whole 16-word burst, the block raises a service request toward the DMA engine.

Software prepares a stream by flushing the store. It then sets the playback enable and the DMA enable together. A transmitter read from an empty store is an underrun: it sets a sticky flag, and the sample driven out is either the last one again or zero, depending on a configuration bit. A write to a full store is dropped and sets a separate sticky overflow flag. Both flags clear when software writes 1 to the matching clear input. One interrupt line combines the underrun condition and the service condition, each with its own enable.

Top module: `pcm_tx_fifo`

## Requirements
- R1: After synchronous reset: fill_level is 0; dma_req, irq, urun_flag and ovf_flag are 0; ser_data is 0.
- R2: Samples leave in the order they were written. A pop on a non-empty store loads the oldest sample into ser_data, visible from the cycle after the pop, and reduces fill_level by 1.
- R3: A write while fill_level equals DEPTH is dropped: fill_level stays at DEPTH and ovf_flag sets. ovf_flag stays set until a cycle with ovf_clr high and no new drop.
- R4: The service condition is tx_en high, fill_level at most thresh*2, and free slots (DEPTH minus fill_level) at least 16. dma_req is the service condition ANDed with dma_en.
- R5: dma_req is 0 whenever tx_en or dma_en is 0, whatever the fill level.
- R6: A pop while fill_level is 0 sets urun_flag. It stays set until a cycle with urun_clr high and no new underrun.
- R7: On an underrun pop, ser_data keeps the previous sample when repeat_last is 1 and becomes 0 when repeat_last is 0.
- R8: A flush pulse empties the store in one cycle (fill_level 0 in the next cycle). A write or pop in the same cycle is ignored and raises no flag.
- R9: irq is (urun_flag AND urun_ie) OR (service condition AND svc_ie). It does not depend on dma_en.
- R10: An underrun pop leaves fill_level at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write strobe on the data register |
| wr_data | input | 16 | Sample written |
| ser_pop | input | 1 | Transmitter takes one sample |
| ser_data | output | 16 | Sample presented to the transmitter |
| flush | input | 1 | One-cycle flush command |
| tx_en | input | 1 | Playback enable |
| dma_en | input | 1 | DMA request enable |
| thresh | input | 4 | Service mark, in units of two entries |
| repeat_last | input | 1 | 1: underrun repeats the last sample, 0: outputs zero |
| urun_ie | input | 1 | Underrun interrupt enable |
| svc_ie | input | 1 | Service interrupt enable |
| urun_clr | input | 1 | Write-1 clear of the underrun flag |
| ovf_clr | input | 1 | Write-1 clear of the overflow flag |
| dma_req | output | 1 | Burst service request |
| irq | output | 1 | Combined interrupt |
| urun_flag | output | 1 | Sticky underrun status |
| ovf_flag | output | 1 | Sticky overflow status |
| fill_level | output | 6 | Entries held |

## Verification
A table of write bursts, pop runs and flushes with a low mark moves the level across the request boundary in both directions. It tells a correct level comparison from an off-by-one. It also checks that every popped sample equals the next value of a write sequence kept in the bench. A high mark with a fill between 16 and 30 separates the free-slot condition from the threshold condition. Underrun pops under each setting of repeat_last show that the held sample and the zero fill are distinct. A flush that coincides with a write and a pop shows that flush takes priority.

// File: rtl/pcm_tx_pkg.sv
// Shared sizing for the playback FIFO.
// Assumes DEPTH is a power of two and at least BURST.
package pcm_tx_pkg;
    localparam int DATA_W   = 16;
    localparam int DEPTH    = 32;
    localparam int BURST    = 16;
    localparam int THR_W    = 4;
    localparam int THR_UNIT = 2;
    localparam int CNT_W    = $clog2(DEPTH) + 1;
endpackage

// File: rtl/ptx_store.sv
// Sample storage: circular buffer with fill counter and output sample register.
// Assumes flush has priority over write and pop; full writes are dropped.
module ptx_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop,
    input  logic              repeat_last,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  level,
    output logic              wr_drop,
    output logic              pop_empty
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              full, empty, do_wr, do_rd;

    // Qualify the requested operations against fill state and flush.
    always_comb begin
        full      = (level == CNT_W'(DEPTH));
        empty     = (level == '0);
        do_wr     = wr_en && !flush && !full;
        do_rd     = pop && !flush && !empty;
        wr_drop   = wr_en && !flush && full;
        pop_empty = pop && !flush && empty;
    end

    // Sample array write, no reset needed.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    // Pointers and fill counter.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= rd_ptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // Output sample register: next sample, held sample or zero fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (do_rd) begin
            rd_data <= mem[rd_ptr];
        end else if (pop_empty && !repeat_last) begin
            rd_data <= '0;
        end
    end
endmodule

// File: rtl/ptx_reqgen.sv
// Service condition from fill level, mark and free-slot room for one burst.
// Assumes the mark is scaled by THR_UNIT entries per step.
module ptx_reqgen #(
    parameter int DEPTH    = 32,
    parameter int BURST    = 16,
    parameter int THR_W    = 4,
    parameter int THR_UNIT = 2,
    localparam int CNT_W   = $clog2(DEPTH) + 1
) (
    input  logic [CNT_W-1:0] level,
    input  logic [THR_W-1:0] thresh,
    input  logic             tx_en,
    input  logic             dma_en,
    output logic             svc,
    output logic             dma_req
);
    logic [CNT_W-1:0] mark, free_slots;

    // Compare level against the mark and the burst room.
    always_comb begin
        mark       = CNT_W'(thresh) * CNT_W'(THR_UNIT);
        free_slots = CNT_W'(DEPTH) - level;
        svc        = tx_en && (level <= mark) && (free_slots >= CNT_W'(BURST));
        dma_req    = svc && dma_en;
    end
endmodule

// File: rtl/ptx_flags.sv
// Sticky error flags with write-one clear and the combined interrupt.
// Assumes a new event in the clear cycle keeps the flag set.
module ptx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic urun_evt,
    input  logic ovf_evt,
    input  logic urun_clr,
    input  logic ovf_clr,
    input  logic svc,
    input  logic urun_ie,
    input  logic svc_ie,
    output logic urun_flag,
    output logic ovf_flag,
    output logic irq
);
    // Set has priority over clear for both flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            urun_flag <= 1'b0;
            ovf_flag  <= 1'b0;
        end else begin
            urun_flag <= urun_evt || (urun_flag && !urun_clr);
            ovf_flag  <= ovf_evt || (ovf_flag && !ovf_clr);
        end
    end

    // Interrupt combines masked underrun and masked service condition.
    always_comb irq = (urun_flag && urun_ie) || (svc && svc_ie);
endmodule

// File: rtl/pcm_tx_fifo.sv
// Playback FIFO top: storage, request generator and status flags.
// Assumes a single write port and a one-sample-per-pop transmitter.
module pcm_tx_fifo
    import pcm_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ser_pop,
    output logic [DATA_W-1:0] ser_data,
    input  logic              flush,
    input  logic              tx_en,
    input  logic              dma_en,
    input  logic [THR_W-1:0]  thresh,
    input  logic              repeat_last,
    input  logic              urun_ie,
    input  logic              svc_ie,
    input  logic              urun_clr,
    input  logic              ovf_clr,
    output logic              dma_req,
    output logic              irq,
    output logic              urun_flag,
    output logic              ovf_flag,
    output logic [CNT_W-1:0]  fill_level
);
    logic wr_drop, pop_empty, svc;

    ptx_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_en(wr_valid), .wr_data(wr_data),
        .pop(ser_pop), .repeat_last(repeat_last),
        .rd_data(ser_data), .level(fill_level),
        .wr_drop(wr_drop), .pop_empty(pop_empty)
    );

    ptx_reqgen #(.DEPTH(DEPTH), .BURST(BURST), .THR_W(THR_W), .THR_UNIT(THR_UNIT)) u_req (
        .level(fill_level), .thresh(thresh), .tx_en(tx_en), .dma_en(dma_en),
        .svc(svc), .dma_req(dma_req)
    );

    ptx_flags u_flags (
        .clk(clk), .rst_n(rst_n),
        .urun_evt(pop_empty), .ovf_evt(wr_drop),
        .urun_clr(urun_clr), .ovf_clr(ovf_clr),
        .svc(svc), .urun_ie(urun_ie), .svc_ie(svc_ie),
        .urun_flag(urun_flag), .ovf_flag(ovf_flag), .irq(irq)
    );
endmodule

// File: rtl/pcm_tx_fifo_chk.sv
// Port-level protocol checks for the playback FIFO, bound to the top.
module pcm_tx_fifo_chk
    import pcm_tx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              ser_pop,
    input logic [DATA_W-1:0] ser_data,
    input logic              flush,
    input logic              tx_en,
    input logic              dma_en,
    input logic              repeat_last,
    input logic              urun_clr,
    input logic              dma_req,
    input logic              urun_flag,
    input logic              ovf_flag,
    input logic [CNT_W-1:0]  fill_level
);
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= CNT_W'(DEPTH)); // R3
    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !flush && fill_level == CNT_W'(DEPTH) |=> ovf_flag && fill_level == CNT_W'(DEPTH)); // R3
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> fill_level == '0); // R8
    AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_en && dma_en) |-> !dma_req); // R5
    AST_REQ_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> fill_level <= CNT_W'(DEPTH - BURST)); // R4
    AST_URUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        urun_flag && !urun_clr |=> urun_flag); // R6
    AST_URUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ser_pop && !flush && fill_level == '0 |=> urun_flag && fill_level == '0); // R10
    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        ser_pop && !flush && fill_level == '0 && !repeat_last |=> ser_data == '0); // R7
    AST_HOLD_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        ser_pop && !flush && fill_level == '0 && repeat_last |=> $stable(ser_data)); // R7
endmodule

bind pcm_tx_fifo pcm_tx_fifo_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .ser_pop(ser_pop),
    .ser_data(ser_data), .flush(flush), .tx_en(tx_en), .dma_en(dma_en),
    .repeat_last(repeat_last), .urun_clr(urun_clr), .dma_req(dma_req),
    .urun_flag(urun_flag), .ovf_flag(ovf_flag), .fill_level(fill_level)
);

// File: tb/pcm_tx_fifo_test.sv
module pcm_tx_fifo_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, wr_valid, ser_pop, flush, tx_en, dma_en, repeat_last;
    logic        urun_ie, svc_ie, urun_clr, ovf_clr;
    logic [15:0] wr_data, ser_data;
    logic [3:0]  thresh;
    logic        dma_req, irq, urun_flag, ovf_flag;
    logic [5:0]  fill_level;

    int total = 0;
    int bad = 0;
    logic [15:0] wr_seq = 16'h100;
    logic [15:0] rd_seq = 16'h100;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_tx_fifo uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .ser_pop(ser_pop), .ser_data(ser_data), .flush(flush),
        .tx_en(tx_en), .dma_en(dma_en), .thresh(thresh),
        .repeat_last(repeat_last), .urun_ie(urun_ie), .svc_ie(svc_ie),
        .urun_clr(urun_clr), .ovf_clr(ovf_clr), .dma_req(dma_req), .irq(irq),
        .urun_flag(urun_flag), .ovf_flag(ovf_flag), .fill_level(fill_level)
    );

    // op: 0 idle, 1 write cnt, 2 pop cnt, 3 flush
    typedef struct packed {
        logic [1:0] op;
        logic [5:0] cnt;
        logic [5:0] lvl;
        logic       req;
    } vec_t;

    // mark = 3 -> request while level <= 6
    localparam vec_t VEC [10] = '{
        '{2'd1, 6'd4,  6'd4,  1'b1},
        '{2'd1, 6'd3,  6'd7,  1'b0},
        '{2'd2, 6'd1,  6'd6,  1'b1},
        '{2'd1, 6'd20, 6'd26, 1'b0},
        '{2'd1, 6'd6,  6'd32, 1'b0},
        '{2'd2, 6'd10, 6'd22, 1'b0},
        '{2'd2, 6'd16, 6'd6,  1'b1},
        '{2'd3, 6'd0,  6'd0,  1'b1},
        '{2'd1, 6'd2,  6'd2,  1'b1},
        '{2'd2, 6'd2,  6'd0,  1'b1}
    };

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic write_n(input int n);
        for (int i = 0; i < n; i++) begin
            wr_valid = 1'b1;
            wr_data  = wr_seq;
            wr_seq   = wr_seq + 1'b1;
            tick();
        end
        wr_valid = 1'b0;
    endtask

    // Pops with data-order check against the bench sequence (R2).
    task automatic pop_n(input int n);
        for (int i = 0; i < n; i++) begin
            ser_pop = 1'b1;
            tick();
            ser_pop = 1'b0;
            check("R2 order", ser_data, rd_seq);
            rd_seq = rd_seq + 1'b1;
        end
    endtask

    task automatic do_flush();
        flush = 1'b1;
        tick();
        flush  = 1'b0;
        rd_seq = wr_seq;
    endtask

    task automatic single_pop();
        ser_pop = 1'b1;
        tick();
        ser_pop = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_valid = 1'b0; ser_pop = 1'b0; flush = 1'b0;
        tx_en = 1'b1; dma_en = 1'b1; repeat_last = 1'b0; thresh = 4'd3;
        urun_ie = 1'b0; svc_ie = 1'b0; urun_clr = 1'b0; ovf_clr = 1'b0;
        wr_data = '0;
        tick(); tick();
        rst_n = 1'b1;
        // R1 reset state
        check("R1 level", fill_level, 0);
        check("R1 urun", urun_flag, 0);
        check("R1 ovf", ovf_flag, 0);
        check("R1 data", ser_data, 0);
        check("R1 irq", irq, 0);
        tx_en = 1'b0;
        #1 check("R1 req", dma_req, 0);
        tx_en = 1'b1;

        // Table walk: level and request after each step (R2, R4, R8)
        for (int v = 0; v < 10; v++) begin
            case (VEC[v].op)
                2'd1: write_n(int'(VEC[v].cnt));
                2'd2: pop_n(int'(VEC[v].cnt));
                2'd3: do_flush();
                default: tick();
            endcase
            check("R4 table level", fill_level, VEC[v].lvl);
            check("R4 table req", dma_req, VEC[v].req);
        end
        check("R3 no ovf at exact fill", ovf_flag, 0);

        // R4 free-slot room with a high mark (limit 30)
        thresh = 4'd15;
        write_n(20);
        check("R4 room short req", dma_req, 0);
        pop_n(4);
        check("R4 room ok req", dma_req, 1);
        // R5 gating
        dma_en = 1'b0;
        #1 check("R5 dma_en low", dma_req, 0);
        dma_en = 1'b1; tx_en = 1'b0;
        #1 check("R5 tx_en low", dma_req, 0);
        tx_en = 1'b1;

        // R3 overflow
        write_n(16);
        check("R3 full level", fill_level, 32);
        wr_valid = 1'b1; wr_data = 16'hDEAD; tick(); wr_valid = 1'b0;
        check("R3 drop level", fill_level, 32);
        check("R3 ovf set", ovf_flag, 1);
        tick();
        check("R3 ovf sticky", ovf_flag, 1);
        ovf_clr = 1'b1; tick(); ovf_clr = 1'b0;
        check("R3 ovf clear", ovf_flag, 0);
        pop_n(32);

        // R7 / R6 / R10 underrun behaviour
        repeat_last = 1'b1;
        single_pop();
        check("R6 urun set", urun_flag, 1);
        check("R10 level stays", fill_level, 0);
        check("R7 repeat last", ser_data, rd_seq - 1'b1);
        repeat_last = 1'b0;
        single_pop();
        check("R7 zero fill", ser_data, 0);
        tick();
        check("R6 sticky", urun_flag, 1);
        // R9 irq from underrun
        urun_ie = 1'b1;
        #1 check("R9 urun irq", irq, 1);
        urun_clr = 1'b1; tick(); urun_clr = 1'b0;
        check("R6 clear", urun_flag, 0);
        check("R9 irq drops", irq, 0);
        urun_ie = 1'b0;
        // R9 service interrupt, independent of dma_en
        dma_en = 1'b0; svc_ie = 1'b1;
        #1 check("R9 svc irq", irq, 1);
        tx_en = 1'b0;
        #1 check("R9 svc needs tx_en", irq, 0);
        tx_en = 1'b1; dma_en = 1'b1; svc_ie = 1'b0;

        // R8 flush priority over write and pop
        write_n(3);
        flush = 1'b1; wr_valid = 1'b1; ser_pop = 1'b1; wr_data = 16'h5555;
        tick();
        flush = 1'b0; wr_valid = 1'b0; ser_pop = 1'b0; rd_seq = wr_seq;
        check("R8 flush level", fill_level, 0);
        check("R8 no urun", urun_flag, 0);
        check("R8 no ovf", ovf_flag, 0);
        write_n(1);
        pop_n(1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule